// File: doc/BRIEF.md
# Programmable Parallel Port Core

This block is a CPU-bus peripheral with three parallel ports, A, B and C, each as wide as the data bus (eight bits by default). Software sets the direction of each port through a control word. Port A and port B each take one direction for all their bits. Port C is split into an upper half and a lower half, and each half has its own direction. Every port has an output latch, a per-bit output-enable vector for tri-state pin buffers, and an input path from the pins.

The CPU reaches the block through an active-low select, two address bits, active-low read and write strobes, and separate write-data and read-data buses. The block samples all of these on the rising clock edge. An access takes effect on an edge where select and its strobe are both low. A read loads the registered read-data bus on that edge. The value comes from the output latch when the port is an output, or from the live pins when it is an input. Only the simple input/output mode is built. Control words that ask for anything else are rejected.

Top module: `ppio_core`

## Requirements
- R1: A synchronous active-high reset makes every port an input. It clears all output latches, all output enables and the read-data bus, so a read of the control register then returns 0x9B.
- R2: Address 00 selects port A, 01 port B, 10 port C and 11 the control register, for both reads and writes.
- R3: When the select input is high, writes change no latch and no direction, and reads leave the read-data bus unchanged.
- R4: An accepted control word sets directions from four bits, where a 1 means input: bit 4 for port A, bit 3 for the upper half of port C, bit 1 for port B and bit 0 for the lower half of port C. Word 0x90 makes port A an input and port B and all of port C outputs.
- R5: A control word is accepted only if bit 7 is 1 and bits 6, 5 and 2 are 0. Any other control word changes nothing.
- R6: Each output-enable bit is 1 exactly when its port, or its half of port C, is an output. All bits of port A and port B, and all bits of each half of port C, share one value.
- R7: A port write loads that port's output latch, whatever the port's direction. The latch drives the port's output lines from the next cycle on.
- R8: A read of an output port, or an output half of port C, returns the latch. A read of an input port or half returns the pins as they stand on the read edge.
- R9: A read of the control register returns {1, 0, 0, A-input, C-upper-input, 0, B-input, C-lower-input}.
- R10: The read-data bus keeps its value on every cycle without a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | W | Write data from the CPU |
| rdata | output | W | Registered read data to the CPU |
| pa_pins | input | W | Port A pin levels |
| pa_out | output | W | Port A output latch |
| pa_oe | output | W | Port A per-bit output enable |
| pb_pins | input | W | Port B pin levels |
| pb_out | output | W | Port B output latch |
| pb_oe | output | W | Port B per-bit output enable |
| pc_pins | input | W | Port C pin levels |
| pc_out | output | W | Port C output latch |
| pc_oe | output | W | Port C per-bit output enable |

## Verification
The bound checker watches these on every cycle: that output enables are uniform within each port or half, the reset values, that a deselected bus leaves the ports untouched, that a port write lands in its latch, that the read bus holds when there is no read, and that a read of an output port returns its latch. The bench scenarios cover what needs a history of control words. These are the bit-to-direction mapping, the rejection of malformed words, the per-half mixing of latch and pins on port C reads, and the control read-back. They are compared against a bench model fed by seeded random traffic and directed corner cases.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } ppio_sel_e;

  typedef struct packed {
    logic a_in;
    logic ch_in;
    logic b_in;
    logic cl_in;
  } ppio_dir_t;

  localparam ppio_dir_t DIR_RESET = '{a_in: 1'b1, ch_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

  // Only simple-mode words are taken: flag bit set, mode fields zero.
  function automatic logic ctrl_ok(input logic [7:0] w);
    return w[7] && (w[6:5] == 2'b00) && !w[2];
  endfunction

  function automatic ppio_dir_t ctrl_to_dir(input logic [7:0] w);
    ppio_dir_t d;
    d.a_in  = w[4];
    d.ch_in = w[3];
    d.b_in  = w[1];
    d.cl_in = w[0];
    return d;
  endfunction

  function automatic logic [7:0] dir_to_ctrl(input ppio_dir_t d);
    return {1'b1, 2'b00, d.a_in, d.ch_in, 1'b0, d.b_in, d.cl_in};
  endfunction

endpackage

// File: rtl/ppio_ctrl_reg.sv
module ppio_ctrl_reg
  import ppio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output ppio_dir_t  dir,
  output logic [7:0] rview
);

  ppio_dir_t dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RESET;
    end else if (we && ctrl_ok(wdata)) begin
      dir_q <= ctrl_to_dir(wdata);
    end
  end

  assign dir   = dir_q;
  assign rview = dir_to_ctrl(dir_q);

endmodule

// File: rtl/ppio_port.sv
module ppio_port #(
  parameter int W   = 8,
  parameter int GRP = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [W-1:0]   wdata,
  input  logic [GRP-1:0] dir_in,
  input  logic [W-1:0]   pins,
  output logic [W-1:0]   lat,
  output logic [W-1:0]   oe,
  output logic [W-1:0]   rview
);

  localparam int GW = W / GRP;

  logic [W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
    end else if (we) begin
      lat_q <= wdata;
    end
  end

  assign lat = lat_q;

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    assign oe[g*GW +: GW]    = {GW{~dir_in[g]}};
    assign rview[g*GW +: GW] = dir_in[g] ? pins[g*GW +: GW] : lat_q[g*GW +: GW];
  end

endmodule

// File: rtl/ppio_rdmux.sv
module ppio_rdmux
  import ppio_pkg::*;
#(
  parameter int W = 8
) (
  input  ppio_sel_e    sel,
  input  logic [W-1:0] a_v,
  input  logic [W-1:0] b_v,
  input  logic [W-1:0] c_v,
  input  logic [7:0]   ctrl_v,
  output logic [W-1:0] data
);

  always_comb begin
    unique case (sel)
      SEL_A:   data = a_v;
      SEL_B:   data = b_v;
      SEL_C:   data = c_v;
      default: data = W'(ctrl_v);
    endcase
  end

endmodule

// File: rtl/ppio_core.sv
module ppio_core
  import ppio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_pins,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_pins,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_pins,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);

  ppio_sel_e    sel;
  logic         wr_act, rd_act;
  ppio_dir_t    dir;
  logic [7:0]   ctrl_v;
  logic [W-1:0] a_v, b_v, c_v, rd_mux;
  logic [W-1:0] rdata_q;

  assign sel    = ppio_sel_e'(addr);
  assign wr_act = ~sel_n & ~wr_n;
  assign rd_act = ~sel_n & ~rd_n;

  ppio_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_act && sel == SEL_CTRL),
    .wdata (wdata[7:0]),
    .dir   (dir),
    .rview (ctrl_v)
  );

  ppio_port #(.W(W), .GRP(1)) u_pa (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_act && sel == SEL_A),
    .wdata  (wdata),
    .dir_in (dir.a_in),
    .pins   (pa_pins),
    .lat    (pa_out),
    .oe     (pa_oe),
    .rview  (a_v)
  );

  ppio_port #(.W(W), .GRP(1)) u_pb (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_act && sel == SEL_B),
    .wdata  (wdata),
    .dir_in (dir.b_in),
    .pins   (pb_pins),
    .lat    (pb_out),
    .oe     (pb_oe),
    .rview  (b_v)
  );

  ppio_port #(.W(W), .GRP(2)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_act && sel == SEL_C),
    .wdata  (wdata),
    .dir_in ({dir.ch_in, dir.cl_in}),
    .pins   (pc_pins),
    .lat    (pc_out),
    .oe     (pc_oe),
    .rview  (c_v)
  );

  ppio_rdmux #(.W(W)) u_mux (
    .sel    (sel),
    .a_v    (a_v),
    .b_v    (b_v),
    .c_v    (c_v),
    .ctrl_v (ctrl_v),
    .data   (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_act) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ppio_core_chk.sv
module ppio_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] pa_pins,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_pins,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pc_pins,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] pc_oe
);

  localparam int H = W / 2;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pa_out == '0 && pb_out == '0 && pc_out == '0 &&
             pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && rdata == '0));

  // R6
  oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1) &&
    (pc_oe[W-1:H] == '0 || pc_oe[W-1:H] == '1) &&
    (pc_oe[H-1:0] == '0 || pc_oe[H-1:0] == '1));

  // R3
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
               $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(rdata)));

  // R7
  port_a_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n && addr == 2'b00) |=> (pa_out == $past(wdata)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_n || rd_n) |=> $stable(rdata));

  // R8
  out_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !rd_n && wr_n && addr == 2'b01 && pb_oe != '0) |=> (rdata == $past(pb_out)));

endmodule

bind ppio_core ppio_core_chk #(.W(W)) chk_i (.*);

// File: tb/ppio_core_tb_top.sv
`timescale 1ns/1ps
module ppio_core_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pa_pins = '0, pb_pins = '0, pc_pins = '0;
  logic [W-1:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic         m_a, m_b, m_ch, m_cl;
  logic [W-1:0] m_la, m_lb, m_lc, m_rd;

  always #5 clk = ~clk;

  ppio_core #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_pins(pa_pins), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_pins(pb_pins), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_pins(pc_pins), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl();
    return {1'b1, 2'b00, m_a, m_ch, 1'b0, m_b, m_cl};
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'b00:   return m_a ? pa_pins : m_la;
      2'b01:   return m_b ? pb_pins : m_lb;
      2'b10:   return {m_ch ? pc_pins[7:4] : m_lc[7:4], m_cl ? pc_pins[3:0] : m_lc[3:0]};
      default: return exp_ctrl();
    endcase
  endfunction

  task automatic model_reset();
    m_a = 1; m_b = 1; m_ch = 1; m_cl = 1;
    m_la = '0; m_lb = '0; m_lc = '0; m_rd = '0;
  endtask

  task automatic check_ports();
    check("R7 port A latch", pa_out, m_la);
    check("R7 port B latch", pb_out, m_lb);
    check("R7 port C latch", pc_out, m_lc);
    check("R6 port A oe", pa_oe, {W{~m_a}});
    check("R6 port B oe", pb_oe, {W{~m_b}});
    check("R6 port C oe", pc_oe, {{4{~m_ch}}, {4{~m_cl}}});
    check("R10 rdata", rdata, m_rd);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d, input logic cs);
    @(negedge clk);
    sel_n = ~cs; wr_n = 1'b0; addr = a; wdata = d;
    @(posedge clk);
    if (cs) begin
      case (a)
        2'b00: m_la = d;
        2'b01: m_lb = d;
        2'b10: m_lc = d;
        default: if (d[7] && d[6:5] == 2'b00 && !d[2]) begin
          m_a = d[4]; m_ch = d[3]; m_b = d[1]; m_cl = d[0];
        end
      endcase
    end
    @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1;
    check_ports();
  endtask

  task automatic bus_read(input logic [1:0] a, input logic cs, input string req);
    logic [W-1:0] e;
    @(negedge clk);
    pa_pins = W'($urandom); pb_pins = W'($urandom); pc_pins = W'($urandom);
    sel_n = ~cs; rd_n = 1'b0; addr = a;
    e = cs ? exp_read(a) : m_rd;
    @(posedge clk);
    @(negedge clk);
    sel_n = 1'b1; rd_n = 1'b1;
    pa_pins = ~pa_pins; pb_pins = ~pb_pins; pc_pins = ~pc_pins;
    m_rd = e;
    check(req, rdata, e);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_ports(); // R1 latches, oe, rdata cleared
    bus_read(2'b11, 1'b1, "R1 control reset value 0x9B");
    check("R1 reset control", rdata, 8'h9B);

    // R4 directed 0x90: A in, B out, C out
    bus_write(2'b11, 8'h90, 1'b1);
    check("R4 0x90 A oe", pa_oe, '0);
    check("R4 0x90 B oe", pb_oe, '1);
    check("R4 0x90 C oe", pc_oe, '1);
    bus_read(2'b11, 1'b1, "R9 control readback 0x90");
    check("R9 readback", rdata, 8'h90);

    // R2 address decode with distinct data
    bus_write(2'b00, 8'hA1, 1'b1);
    bus_write(2'b01, 8'hB2, 1'b1);
    bus_write(2'b10, 8'hC3, 1'b1);
    bus_read(2'b00, 1'b1, "R2/R8 read A (input pins)");
    bus_read(2'b01, 1'b1, "R2/R8 read B (latch)");
    bus_read(2'b10, 1'b1, "R2/R8 read C (latch)");

    // R5 rejected words
    bus_write(2'b11, 8'h94, 1'b1);
    bus_write(2'b11, 8'hB0, 1'b1);
    bus_write(2'b11, 8'h10, 1'b1);
    bus_read(2'b11, 1'b1, "R5 rejected words keep 0x90");
    check("R5 control unchanged", rdata, 8'h90);

    // R8 split port C: upper input, lower output
    bus_write(2'b11, 8'h88, 1'b1);
    bus_write(2'b10, 8'h5A, 1'b1);
    bus_read(2'b10, 1'b1, "R8 split C read");

    // R3 deselected access
    bus_write(2'b00, 8'hFF, 1'b0);
    bus_write(2'b11, 8'h9B, 1'b0);
    bus_read(2'b00, 1'b0, "R3 deselected read holds rdata");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [W-1:0] d;
      op = $urandom_range(0, 9);
      d  = W'($urandom);
      if (op < 3) bus_write(2'($urandom_range(0, 2)), d, 1'b1);
      else if (op == 3) bus_write(2'b11, {1'b1, 2'b00, d[4:3], 1'b0, d[1:0]}, 1'b1);
      else if (op == 4) bus_write(2'b11, d, 1'b1);
      else if (op < 8) bus_read(2'($urandom), 1'b1, "R8/R9 random read");
      else if (op == 8) bus_write(2'($urandom), d, 1'b0);
      else bus_read(2'($urandom), 1'b0, "R3 random deselected read");
    end

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    check_ports();
    bus_read(2'b11, 1'b1, "R1 control after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule